// File: doc/BRIEF.md
# Request Batch Marker

This block keeps one mark bit for every slot of a shared memory request queue and uses those bits to group requests into batches. Each slot holds a thread number, a target bank and its arrival order. Whenever the queue holds pending requests but none of them is marked, the block forms a new batch in a single step. It marks, separately for every (thread, bank) pair, up to `mark_cap` of that pair's earliest-arrived pending requests.

The downstream request picker reads `mark_vec` and serves marked requests ahead of unmarked ones, so requests are never reordered across batches. `bank_has_mark` tells the picker which banks still hold marked work. A bank whose flag is low may serve unmarked requests, which keeps the scheme work-conserving. `batch_start` pulses for one cycle in the cycle the new marks first appear, so a ranking stage can latch a fresh thread order. Requests that arrive while a batch is open are not marked. Completing a request clears both its pending state and its mark. A cap of zero switches batching off.

Top module: `batch_marker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mark_vec`, `bank_has_mark` and `batch_start` are all zero.
- R2: If at a rising edge no pending slot is marked, at least one slot is pending and `mark_cap` is non-zero, then a batch is formed at that edge. From that edge on, `batch_start` is high for exactly that one cycle, and `mark_vec` shows the new batch.
- R3: For each (thread, bank) pair, batch formation marks exactly min(`mark_cap`, pending count of that pair) slots. These are the pair's earliest-arrived slots by allocation order, whatever their slot indices.
- R4: No batch is formed while any slot is still marked. A slot allocated while a batch is open stays unmarked.
- R5: A completion (`done_valid` with `done_idx`) clears that slot's mark at the same edge. A slot allocated again afterwards starts unmarked.
- R6: While `mark_cap` is zero, no batch forms, no mark is set and `batch_start` stays low, even when requests are pending.
- R7: `bank_has_mark[b]` is high exactly when some marked slot targets bank b, and it is updated in the same cycle as `mark_vec`.
- R8: The cap applies to each (thread, bank) pair on its own. A thread with requests to several banks gets up to `mark_cap` marks in every bank, and the threads sharing a bank do not limit one another.
- R9: A mark bit only rises in a cycle in which `batch_start` is high. `mark_cap` is sampled only at formation, so changing it while a batch is open leaves the current marks alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one DRAM scheduling cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A new request is written into slot `alloc_idx` |
| alloc_idx | input | IDX_W | Slot index of the new request |
| alloc_tid | input | TID_W | Thread number of the new request |
| alloc_bank | input | BANK_W | Target bank of the new request |
| done_valid | input | 1 | Slot `done_idx` has been served and leaves the queue |
| done_idx | input | IDX_W | Slot index of the served request |
| mark_cap | input | CAP_W | Per-(thread, bank) marking limit; zero disables batching |
| mark_vec | output | ENTRIES | Mark bit per slot (registered) |
| bank_has_mark | output | 2**BANK_W | Per-bank flag: a marked request targets this bank (registered) |
| batch_start | output | 1 | One-cycle pulse when a new batch appears (registered) |

## Verification
The assertions take for granted that `alloc_idx` names a free slot and `done_idx` names a pending one, and that the two never name the same slot in one cycle. Outside those conditions the slot bookkeeping is undefined. The stimulus keeps to these rules by tracking slot occupancy in its scenario sequence, and it issues at most one allocation or one completion per cycle. It fills the queue while the cap is zero so that a batch can be formed over several pending requests at once. Allocations go into slots in descending index order, so earliest arrival and lowest index disagree.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned BM_ENTRIES = 16;
  localparam int unsigned BM_TID_W   = 2;
  localparam int unsigned BM_BANK_W  = 3;
  localparam int unsigned BM_CAP_W   = 3;
endpackage

// File: rtl/bm_entry_table.sv
module bm_entry_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned BANK_W  = 3,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               alloc_valid,
  input  logic [IDX_W-1:0]                   alloc_idx,
  input  logic [TID_W-1:0]                   alloc_tid,
  input  logic [BANK_W-1:0]                  alloc_bank,
  input  logic                               done_valid,
  input  logic [IDX_W-1:0]                   done_idx,
  output logic [ENTRIES-1:0]                 valid_q,
  output logic [ENTRIES-1:0][TID_W-1:0]      tid_q,
  output logic [ENTRIES-1:0][BANK_W-1:0]     bank_q,
  output logic [ENTRIES-1:0][ENTRIES-1:0]    older_q
);
  // older_q[i][j] = 1 : slot j arrived before slot i (relative order, no wrap)
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      tid_q   <= '0;
      bank_q  <= '0;
      older_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (done_valid && done_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
        if (alloc_valid && alloc_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tid_q[i]   <= alloc_tid;
          bank_q[i]  <= alloc_bank;
          older_q[i] <= valid_q & ~(ENTRIES'(1) << i);
        end else if (alloc_valid) begin
          older_q[i][alloc_idx] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bm_select.sv
module bm_select #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned CAP_W   = 3
) (
  input  logic [ENTRIES-1:0]              valid,
  input  logic [ENTRIES-1:0][TID_W-1:0]   tid,
  input  logic [ENTRIES-1:0][BANK_W-1:0]  bank,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
  input  logic [CAP_W-1:0]                cap,
  output logic [ENTRIES-1:0]              sel
);
  // A slot is chosen when fewer than cap older pending slots share its pair.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_comb begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && valid[j] && older[i][j] &&
            tid[j] == tid[i] && bank[j] == bank[i])
          ahead++;
      end
      sel[i] = valid[i] && (ahead < int'(cap));
    end
  end
endmodule

// File: rtl/bm_mark_reg.sv
module bm_mark_reg #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned CAP_W   = 3,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned BANKS  = 1 << BANK_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              valid,
  input  logic [ENTRIES-1:0]              sel,
  input  logic [ENTRIES-1:0][BANK_W-1:0]  bank,
  input  logic [CAP_W-1:0]                cap,
  input  logic                            done_valid,
  input  logic [IDX_W-1:0]                done_idx,
  output logic [ENTRIES-1:0]              mark_q,
  output logic [BANKS-1:0]                bank_flag_q,
  output logic                            start_q
);
  logic                 form;
  logic [ENTRIES-1:0]   clr;
  logic [ENTRIES-1:0]   mark_d;
  logic [BANKS-1:0]     flag_d;

  assign form = (mark_q == '0) && (|valid) && (cap != '0);

  always_comb begin
    clr    = done_valid ? (ENTRIES'(1) << done_idx) : '0;
    mark_d = (form ? sel : mark_q) & ~clr;
    flag_d = '0;
    for (int b = 0; b < BANKS; b++)
      for (int i = 0; i < ENTRIES; i++)
        if (mark_d[i] && bank[i] == BANK_W'(b)) flag_d[b] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_q      <= '0;
      bank_flag_q <= '0;
      start_q     <= 1'b0;
    end else begin
      mark_q      <= mark_d;
      bank_flag_q <= flag_d;
      start_q     <= form;
    end
  end
endmodule

// File: rtl/batch_marker.sv
module batch_marker #(
  parameter int unsigned ENTRIES = bm_pkg::BM_ENTRIES,
  parameter int unsigned TID_W   = bm_pkg::BM_TID_W,
  parameter int unsigned BANK_W  = bm_pkg::BM_BANK_W,
  parameter int unsigned CAP_W   = bm_pkg::BM_CAP_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned BANKS  = 1 << BANK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [TID_W-1:0]   alloc_tid,
  input  logic [BANK_W-1:0]  alloc_bank,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic [CAP_W-1:0]   mark_cap,
  output logic [ENTRIES-1:0] mark_vec,
  output logic [BANKS-1:0]   bank_has_mark,
  output logic               batch_start
);
  logic [ENTRIES-1:0]              valid_q;
  logic [ENTRIES-1:0][TID_W-1:0]   tid_q;
  logic [ENTRIES-1:0][BANK_W-1:0]  bank_q;
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;
  logic [ENTRIES-1:0]              sel;

  bm_entry_table #(.ENTRIES(ENTRIES), .TID_W(TID_W), .BANK_W(BANK_W)) u_table (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .alloc_tid(alloc_tid), .alloc_bank(alloc_bank),
    .done_valid(done_valid), .done_idx(done_idx),
    .valid_q(valid_q), .tid_q(tid_q), .bank_q(bank_q), .older_q(older_q)
  );

  bm_select #(.ENTRIES(ENTRIES), .TID_W(TID_W), .BANK_W(BANK_W), .CAP_W(CAP_W)) u_select (
    .valid(valid_q), .tid(tid_q), .bank(bank_q), .older(older_q),
    .cap(mark_cap), .sel(sel)
  );

  bm_mark_reg #(.ENTRIES(ENTRIES), .BANK_W(BANK_W), .CAP_W(CAP_W)) u_marks (
    .clk(clk), .rst(rst),
    .valid(valid_q), .sel(sel), .bank(bank_q), .cap(mark_cap),
    .done_valid(done_valid), .done_idx(done_idx),
    .mark_q(mark_vec), .bank_flag_q(bank_has_mark), .start_q(batch_start)
  );
endmodule

// File: rtl/batch_marker_chk.sv
module batch_marker_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned BANKS   = 8,
  parameter int unsigned CAP_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [ENTRIES-1:0] mark_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [BANKS-1:0]   bank_has_mark,
  input logic               batch_start,
  input logic [CAP_W-1:0]   mark_cap
);
  p_mark_pending_r5: assert property (@(posedge clk) disable iff (rst)
    (mark_vec & ~valid_vec) == '0);

  p_rise_at_start_r9: assert property (@(posedge clk) disable iff (rst)
    ((mark_vec & ~$past(mark_vec)) != '0) |-> batch_start);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    batch_start |-> ($past(mark_vec) == '0));

  p_cap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (mark_cap == '0) |=> !batch_start);

  p_form_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (mark_vec == '0 && valid_vec != '0 && mark_cap != '0) |=> batch_start);

  p_bank_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (mark_vec != '0) == (bank_has_mark != '0));
endmodule

bind batch_marker batch_marker_chk #(.ENTRIES(ENTRIES), .BANKS(BANKS), .CAP_W(CAP_W)) u_chk (
  .clk(clk), .rst(rst), .mark_vec(mark_vec), .valid_vec(valid_q),
  .bank_has_mark(bank_has_mark), .batch_start(batch_start), .mark_cap(mark_cap)
);

// File: tb/test_batch_marker.sv
module test_batch_marker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 1'b0;
  logic [3:0]  alloc_idx = '0;
  logic [1:0]  alloc_tid = '0;
  logic [2:0]  alloc_bank = '0;
  logic        done_valid = 1'b0;
  logic [3:0]  done_idx = '0;
  logic [2:0]  mark_cap = '0;
  logic [15:0] mark_vec;
  logic [7:0]  bank_has_mark;
  logic        batch_start;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  batch_marker i_batch_marker (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .alloc_tid(alloc_tid), .alloc_bank(alloc_bank),
    .done_valid(done_valid), .done_idx(done_idx),
    .mark_cap(mark_cap), .mark_vec(mark_vec),
    .bank_has_mark(bank_has_mark), .batch_start(batch_start)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int idx, int tid, int bank);
    alloc_valid = 1'b1;
    alloc_idx   = 4'(idx);
    alloc_tid   = 2'(tid);
    alloc_bank  = 3'(bank);
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic retire(int idx);
    done_valid = 1'b1;
    done_idx   = 4'(idx);
    tick();
    done_valid = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1 mark_vec in reset", 32'(mark_vec), 0);
    chk("R1 batch_start in reset", 32'(batch_start), 0);
    rst = 1'b0;
    tick();
    chk("R1 bank_has_mark after reset", 32'(bank_has_mark), 0);
    chk("R1 mark_vec after reset", 32'(mark_vec), 0);
  endtask

  task automatic t_fill_cap_zero();
    mark_cap = 3'd0;
    // descending slot order: arrival order differs from index order
    put(4, 0, 1); put(3, 0, 1); put(2, 0, 1); put(1, 0, 1); put(0, 0, 1);
    put(5, 0, 2); put(6, 1, 1);
    tick(); tick();
    chk("R6 no marks with cap zero", 32'(mark_vec), 0);
    chk("R6 no batch_start with cap zero", 32'(batch_start), 0);
  endtask

  task automatic t_first_batch();
    mark_cap = 3'd2;
    tick();
    chk("R2 batch_start pulse", 32'(batch_start), 1);
    chk("R3 R8 oldest two per pair marked", 32'(mark_vec), 32'h0078);
    chk("R7 bank flags", 32'(bank_has_mark), 32'h06);
    tick();
    chk("R2 pulse lasts one cycle", 32'(batch_start), 0);
    chk("R2 marks held", 32'(mark_vec), 32'h0078);
  endtask

  task automatic t_mid_batch();
    put(7, 2, 3);
    chk("R4 late arrival unmarked", 32'(mark_vec), 32'h0078);
    retire(3);
    chk("R5 completion clears mark", 32'(mark_vec), 32'h0070);
    chk("R4 no batch while marks remain", 32'(batch_start), 0);
  endtask

  task automatic t_drain();
    retire(4);
    retire(5);
    chk("R4 still one mark left", 32'(mark_vec), 32'h0040);
    retire(6);
    chk("R4 drained, no start yet", 32'(mark_vec), 0);
    chk("R4 drained, no pulse yet", 32'(batch_start), 0);
    tick();
    chk("R2 second batch pulse", 32'(batch_start), 1);
    chk("R3 second batch marks", 32'(mark_vec), 32'h0086);
    chk("R7 second batch bank flags", 32'(bank_has_mark), 32'h0A);
  endtask

  task automatic t_realloc();
    retire(1);
    chk("R5 mark cleared on completion", 32'(mark_vec), 32'h0084);
    put(1, 2, 3);
    chk("R5 reused slot unmarked", 32'(mark_vec), 32'h0084);
  endtask

  task automatic t_cap_one();
    mark_cap = 3'd1;
    put(8, 0, 1);
    chk("R9 cap change leaves marks", 32'(mark_vec), 32'h0084);
    retire(2);
    retire(7);
    chk("R4 drained again", 32'(mark_vec), 0);
    tick();
    chk("R2 third batch pulse", 32'(batch_start), 1);
    chk("R3 cap one picks oldest per pair", 32'(mark_vec), 32'h0003);
    chk("R7 third batch bank flags", 32'(bank_has_mark), 32'h0A);
  endtask

  task automatic t_disable();
    mark_cap = 3'd0;
    retire(0);
    retire(1);
    tick(); tick();
    chk("R6 pending slot, cap zero, no mark", 32'(mark_vec), 0);
    chk("R6 pending slot, cap zero, no pulse", 32'(batch_start), 0);
    chk("R7 no flags without marks", 32'(bank_has_mark), 0);
    mark_cap = 3'd3;
    tick();
    chk("R2 batch after re-enable", 32'(mark_vec), 32'h0100);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_cap_zero();
    t_first_batch();
    t_mid_batch();
    t_drain();
    t_realloc();
    t_cap_one();
    t_disable();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule